// File: doc/BRIEF.md
# Payload Bit Coder with Whitening, Hamming FEC and Manchester

This block turns payload bytes into a serial line bitstream and back again. On the send side each accepted byte can be XOR-scrambled with a PN7 sequence, split into two nibbles that are each expanded into a 7-bit Hamming codeword, and finally Manchester coded. Every stage has its own enable. On the receive side the same chain runs in reverse. Manchester pairs are folded back into single bits, codewords are checked and single-bit errors repaired, and the scrambling is removed. The result is delivered as a byte with a one-cycle valid pulse.

Preamble, sync word and CRC generation sit in front of this block. A frame-start pulse sent with each packet reseeds both scramblers, realigns the receive framing and clears the two sticky status flags. The first flag reports that at least one codeword was corrected. The second reports that at least one Manchester pair was invalid.

Top module: `payload_coder`

## Requirements
- R1: After reset `tx_ready` is 1, `tx_bit_valid` and `rx_byte_valid` are 0, and both status flags are 0.
- R2: When whitening is enabled, each byte is XORed with 8 consecutive outputs of a 7-bit LFSR with polynomial x^7+x^4+1. The output is the state MSB and the next state is {s[5:0], s[6]^s[3]}. The first output applies to the byte MSB. The state is seeded with all ones at frame start and advances 8 steps per byte. When whitening is disabled, bytes pass unchanged and the sequence still advances.
- R3: When FEC is enabled, the high nibble is coded first. Each codeword is sent MSB first as d3 d2 d1 d0 p2 p1 p0, with p2=d3^d2^d0, p1=d3^d1^d0 and p0=d2^d1^d0, giving 14 coded bits per byte. When FEC is disabled, the 8 byte bits are sent MSB first.
- R4: When Manchester is enabled, each coded bit becomes two line bits: 1 becomes 1 then 0, and 0 becomes 0 then 1.
- R5: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. Its first line bit appears with `tx_bit_valid` after that edge, one line bit per cycle without gaps. `tx_ready` stays 0 until the last line bit has been sent.
- R6: The receiver undoes the enabled stages in reverse order. `rx_byte` with a one-cycle `rx_byte_valid` appears on the edge that follows the last line bit of a byte.
- R7: A single flipped bit in any of the 7 positions of a codeword is corrected.
- R8: `fec_fixed_flag` goes to 1 after a corrected codeword and holds until the next frame start. Error-free frames leave it at 0.
- R9: A received Manchester pair of 00 or 11 sets the sticky `manch_err_flag`. The decoded bit is taken from the first half of the pair.
- R10: `frame_start` clears both flags and resets the receive pair and codeword alignment, so a stray bit sent before it does not shift later bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous-free reset, sampled on clk |
| frame_start | input | 1 | Per-packet pulse: reseed scramblers, clear flags, realign |
| cfg_whiten | input | 1 | Enable PN7 whitening |
| cfg_fec | input | 1 | Enable (7,4) Hamming coding |
| cfg_manch | input | 1 | Enable Manchester coding |
| tx_byte | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_byte` is offered |
| tx_ready | output | 1 | Coder can take a byte |
| tx_bit | output | 1 | Serial line bit out |
| tx_bit_valid | output | 1 | `tx_bit` carries a line bit |
| rx_bit | input | 1 | Serial line bit in |
| rx_bit_valid | input | 1 | `rx_bit` carries a line bit |
| rx_byte | output | 8 | Decoded byte |
| rx_byte_valid | output | 1 | One-cycle pulse with `rx_byte` |
| fec_fixed_flag | output | 1 | Sticky: a codeword was corrected |
| manch_err_flag | output | 1 | Sticky: an invalid Manchester pair arrived |

## Verification
The first line bit of a byte is due in the cycle right after the accepting edge, and bit i is due i cycles later. The bench therefore drives each byte on a falling edge and then reads one line bit on every following falling edge, as many times as the enabled stages predict (8, 14, 16 or 28). The decoded byte and both flags are due one edge after the last received line bit is presented. The bench reads them on the very next falling edge, so a result that arrives a cycle early or late is reported. The sweep covers all eight stage combinations against a bench model of the scrambler, codewords and pairs. It also injects errors into every codeword position and into Manchester pairs.

// File: rtl/pcoder_pkg.sv
package pcoder_pkg;
  localparam int NIB_W    = 4;
  localparam int PAR_W    = 3;
  localparam int CW_W     = NIB_W + PAR_W;
  localparam int BYTE_W   = 2 * NIB_W;
  localparam int PN_W     = 7;
  localparam int FEC_BITS = 2 * CW_W;
  localparam int CNT_W    = $clog2(FEC_BITS + 1);

  typedef logic [NIB_W-1:0]  nib_t;
  typedef logic [CW_W-1:0]   cw_t;
  typedef logic [PAR_W-1:0]  syn_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PN_W-1:0]   pn_t;

  // codeword = {d3,d2,d1,d0,p2,p1,p0}
  function automatic cw_t ham_encode(nib_t d);
    return {d, d[3] ^ d[2] ^ d[0], d[3] ^ d[1] ^ d[0], d[2] ^ d[1] ^ d[0]};
  endfunction

  function automatic syn_t ham_syndrome(cw_t c);
    return {c[6] ^ c[5] ^ c[3] ^ c[2],
            c[6] ^ c[4] ^ c[3] ^ c[1],
            c[5] ^ c[4] ^ c[3] ^ c[0]};
  endfunction

  // bit to flip for a given syndrome
  function automatic cw_t ham_flip(syn_t s);
    case (s)
      3'b110:  return 7'b1000000;
      3'b101:  return 7'b0100000;
      3'b011:  return 7'b0010000;
      3'b111:  return 7'b0001000;
      3'b100:  return 7'b0000100;
      3'b010:  return 7'b0000010;
      3'b001:  return 7'b0000001;
      default: return 7'b0000000;
    endcase
  endfunction

  // x^7 + x^4 + 1, output is the state MSB
  function automatic pn_t pn7_step(pn_t s);
    return {s[5:0], s[6] ^ s[3]};
  endfunction

  function automatic byte_t pn7_mask(pn_t s);
    pn_t   t;
    byte_t m;
    t = s;
    for (int i = BYTE_W - 1; i >= 0; i--) begin
      m[i] = t[PN_W-1];
      t    = pn7_step(t);
    end
    return m;
  endfunction

  function automatic pn_t pn7_advance(pn_t s);
    pn_t t;
    t = s;
    for (int i = 0; i < BYTE_W; i++) t = pn7_step(t);
    return t;
  endfunction
endpackage

// File: rtl/pc_pn7.sv
module pc_pn7 import pcoder_pkg::*; #(
  parameter pn_t SEED = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  advance,
  output byte_t mask
);
  pn_t st;

  always_ff @(posedge clk) begin
    if (!rst_n)       st <= SEED;
    else if (restart) st <= SEED;
    else if (advance) st <= pn7_advance(st);
  end

  assign mask = pn7_mask(st);

  // R2
  pn_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n) st != '0);
endmodule

// File: rtl/pc_tx_path.sv
module pc_tx_path import pcoder_pkg::*; #(
  parameter pn_t SEED = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  en_white,
  input  logic  en_fec,
  input  logic  en_manch,
  input  byte_t din,
  input  logic  din_valid,
  output logic  din_ready,
  output logic  line_bit,
  output logic  line_valid
);
  logic                busy, half, m_manch;
  logic [FEC_BITS-1:0] sh;
  logic [CNT_W-1:0]    left;
  byte_t               mask, wb;
  logic                accept;

  assign din_ready = !busy;
  assign accept    = din_valid && din_ready;

  pc_pn7 #(.SEED(SEED)) u_pn (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(accept), .mask(mask)
  );

  assign wb = din ^ (en_white ? mask : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; half <= 1'b0; m_manch <= 1'b0; sh <= '0; left <= '0;
    end else if (restart) begin
      busy <= 1'b0; half <= 1'b0; left <= '0;
    end else if (accept) begin
      busy    <= 1'b1;
      half    <= 1'b0;
      m_manch <= en_manch;
      if (en_fec) begin
        sh   <= {ham_encode(wb[BYTE_W-1:NIB_W]), ham_encode(wb[NIB_W-1:0])};
        left <= CNT_W'(FEC_BITS);
      end else begin
        sh   <= {wb, {(FEC_BITS-BYTE_W){1'b0}}};
        left <= CNT_W'(BYTE_W);
      end
    end else if (busy) begin
      if (m_manch && !half) begin
        half <= 1'b1;
      end else begin
        half <= 1'b0;
        sh   <= sh << 1;
        left <= left - CNT_W'(1);
        if (left == CNT_W'(1)) busy <= 1'b0;
      end
    end
  end

  assign line_valid = busy;
  assign line_bit   = sh[FEC_BITS-1] ^ (m_manch & half);

  // R5
  accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !restart) |=> (line_valid && !din_ready));

  // R4
  manch_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_valid && m_manch && half) |-> (line_bit != $past(line_bit)));
endmodule

// File: rtl/pc_rx_path.sv
module pc_rx_path import pcoder_pkg::*; #(
  parameter pn_t SEED = '1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  en_white,
  input  logic  en_fec,
  input  logic  en_manch,
  input  logic  bit_in,
  input  logic  bit_valid,
  output byte_t dout,
  output logic  dout_valid,
  output logic  fix_flag,
  output logic  merr_flag
);
  logic              phase, first;
  logic [BYTE_W-2:0] sr;
  logic [2:0]        cnt;
  logic              nph;
  nib_t              hi;
  logic              cb_v, cb, manch_bad;
  cw_t               cw_full, fixed;
  syn_t              syn;
  logic              cw_done, corr_evt, byte_done;
  byte_t             raw, mask;

  always_comb begin
    if (en_manch) begin
      cb_v      = bit_valid && phase;
      cb        = first;
      manch_bad = cb_v && (first == bit_in);
    end else begin
      cb_v      = bit_valid;
      cb        = bit_in;
      manch_bad = 1'b0;
    end
  end

  assign cw_full   = {sr[CW_W-2:0], cb};
  assign syn       = ham_syndrome(cw_full);
  assign fixed     = cw_full ^ ham_flip(syn);
  assign cw_done   = cb_v && en_fec && (cnt == 3'd6);
  assign corr_evt  = cw_done && (syn != '0);
  assign byte_done = cb_v && (en_fec ? (cnt == 3'd6 && nph) : (cnt == 3'd7));
  assign raw       = en_fec ? {hi, fixed[CW_W-1:PAR_W]} : {sr, cb};

  pc_pn7 #(.SEED(SEED)) u_pn (
    .clk(clk), .rst_n(rst_n), .restart(restart), .advance(byte_done), .mask(mask)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= 1'b0; first <= 1'b0; sr <= '0; cnt <= '0; nph <= 1'b0; hi <= '0;
      dout <= '0; dout_valid <= 1'b0; fix_flag <= 1'b0; merr_flag <= 1'b0;
    end else begin
      dout_valid <= 1'b0;
      if (restart) begin
        phase <= 1'b0; cnt <= '0; nph <= 1'b0;
        fix_flag <= 1'b0; merr_flag <= 1'b0;
      end else begin
        if (en_manch && bit_valid) begin
          phase <= !phase;
          if (!phase) first <= bit_in;
        end
        if (cb_v) begin
          sr <= {sr[BYTE_W-3:0], cb};
          if (cw_done) begin
            cnt <= '0;
            nph <= !nph;
            if (!nph) hi <= fixed[CW_W-1:PAR_W];
          end else if (!en_fec && cnt == 3'd7) begin
            cnt <= '0;
          end else begin
            cnt <= cnt + 3'd1;
          end
        end
        if (byte_done) begin
          dout       <= raw ^ (en_white ? mask : '0);
          dout_valid <= 1'b1;
        end
        if (corr_evt)  fix_flag  <= 1'b1;
        if (manch_bad) merr_flag <= 1'b1;
      end
    end
  end

  // R6
  byte_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |=> !dout_valid);

  // R7
  corr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (corr_evt && !restart) |=> fix_flag);

  // R8
  fix_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fix_flag && !restart) |=> fix_flag);

  // R9
  merr_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (manch_bad && !restart) |=> merr_flag);

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!fix_flag && !merr_flag && !dout_valid));
endmodule

// File: rtl/payload_coder.sv
module payload_coder import pcoder_pkg::*; #(
  parameter pn_t PN_SEED = 7'h7F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       cfg_whiten,
  input  logic       cfg_fec,
  input  logic       cfg_manch,
  input  logic [7:0] tx_byte,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic       tx_bit,
  output logic       tx_bit_valid,
  input  logic       rx_bit,
  input  logic       rx_bit_valid,
  output logic [7:0] rx_byte,
  output logic       rx_byte_valid,
  output logic       fec_fixed_flag,
  output logic       manch_err_flag
);
  pc_tx_path #(.SEED(PN_SEED)) u_tx (
    .clk(clk), .rst_n(rst_n), .restart(frame_start),
    .en_white(cfg_whiten), .en_fec(cfg_fec), .en_manch(cfg_manch),
    .din(tx_byte), .din_valid(tx_valid), .din_ready(tx_ready),
    .line_bit(tx_bit), .line_valid(tx_bit_valid)
  );

  pc_rx_path #(.SEED(PN_SEED)) u_rx (
    .clk(clk), .rst_n(rst_n), .restart(frame_start),
    .en_white(cfg_whiten), .en_fec(cfg_fec), .en_manch(cfg_manch),
    .bit_in(rx_bit), .bit_valid(rx_bit_valid),
    .dout(rx_byte), .dout_valid(rx_byte_valid),
    .fix_flag(fec_fixed_flag), .merr_flag(manch_err_flag)
  );

  // R1
  reset_idle_chk: assert property (@(posedge clk) $past(!rst_n) |-> (tx_ready && !tx_bit_valid && !rx_byte_valid));
endmodule

// File: tb/payload_coder_tb.sv
module payload_coder_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, frame_start, cfg_whiten, cfg_fec, cfg_manch;
  logic [7:0] tx_byte;
  logic       tx_valid, tx_ready, tx_bit, tx_bit_valid;
  logic       rx_bit, rx_bit_valid;
  logic [7:0] rx_byte;
  logic       rx_byte_valid, fec_fixed_flag, manch_err_flag;

  payload_coder u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .cfg_whiten(cfg_whiten), .cfg_fec(cfg_fec), .cfg_manch(cfg_manch),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_bit(tx_bit), .tx_bit_valid(tx_bit_valid),
    .rx_bit(rx_bit), .rx_bit_valid(rx_bit_valid),
    .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid),
    .fec_fixed_flag(fec_fixed_flag), .manch_err_flag(manch_err_flag)
  );

  int checks = 0;
  int errors = 0;
  logic [6:0] mstate, mnext;
  logic lb [28];
  int nlb;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] benc(input logic [3:0] n);
    return {n, ^(n & 4'b1101), ^(n & 4'b1011), ^(n & 4'b0111)};
  endfunction

  // expected line bits from the requirements (R2, R3, R4)
  task automatic build_line(input logic [7:0] b);
    logic [6:0] s, eh, el;
    logic [7:0] m, w;
    logic c [14];
    int nc;
    s = mstate;
    for (int k = 7; k >= 0; k--) begin
      m[k] = s[6];
      s = {s[5:0], s[6] ^ s[3]};
    end
    mnext = s;
    w = cfg_whiten ? (b ^ m) : b;
    if (cfg_fec) begin
      eh = benc(w[7:4]);
      el = benc(w[3:0]);
      for (int k = 0; k < 7; k++) begin
        c[k]   = eh[6-k];
        c[7+k] = el[6-k];
      end
      nc = 14;
    end else begin
      for (int k = 0; k < 8; k++) c[k] = w[7-k];
      nc = 8;
    end
    if (cfg_manch) begin
      for (int k = 0; k < nc; k++) begin
        lb[2*k]   = c[k];
        lb[2*k+1] = ~c[k];
      end
      nlb = 2 * nc;
    end else begin
      for (int k = 0; k < nc; k++) lb[k] = c[k];
      nlb = nc;
    end
  endtask

  task automatic setcfg(input logic w, input logic f, input logic m);
    @(negedge clk);
    cfg_whiten = w; cfg_fec = f; cfg_manch = m;
  endtask

  task automatic fstart();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    mstate = 7'h7F;
  endtask

  task automatic xfer(input logic [7:0] b, input int fa, input int fb, input logic [7:0] exp_rx);
    int mism;
    build_line(b);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R5 ready when idle", int'(tx_ready), 1);
    tx_byte = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    mism = 0;
    for (int i = 0; i < nlb; i++) begin
      if (i > 0) @(negedge clk);
      if (!tx_bit_valid || tx_bit !== lb[i]) mism++;
      if (i > 0 && tx_ready) mism++;
    end
    chk(mism == 0, "R2 R3 R4 R5 line bits", mism, 0);
    mstate = mnext;
    for (int i = 0; i < nlb; i++) begin
      @(negedge clk);
      rx_bit_valid = 1'b1;
      rx_bit = lb[i] ^ ((i == fa) || (i == fb));
    end
    @(negedge clk);
    rx_bit_valid = 1'b0;
    chk(rx_byte_valid && rx_byte == exp_rx, "R6 decoded byte", int'(rx_byte), int'(exp_rx));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0;
    cfg_whiten = 1'b0; cfg_fec = 1'b0; cfg_manch = 1'b0;
    tx_byte = '0; tx_valid = 1'b0; rx_bit = 1'b0; rx_bit_valid = 1'b0;
    mstate = 7'h7F;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(tx_ready && !tx_bit_valid && !rx_byte_valid, "R1 idle outputs",
        {tx_ready, tx_bit_valid, rx_byte_valid}, 3'b100);
    chk(!fec_fixed_flag && !manch_err_flag, "R1 flags", {fec_fixed_flag, manch_err_flag}, 0);

    // sweep all stage combinations, clean loopback (R2 R3 R4 R6 R8)
    for (int cfg = 0; cfg < 8; cfg++) begin
      setcfg(cfg[0], cfg[1], cfg[2]);
      fstart();
      for (int i = 0; i < 48; i++) begin
        logic [7:0] b;
        b = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'((i * 53 + cfg * 7) & 255);
        xfer(b, -1, -1, b);
      end
      chk(!fec_fixed_flag, "R8 no correction on clean frame", int'(fec_fixed_flag), 0);
      chk(!manch_err_flag, "R9 no pair error on clean frame", int'(manch_err_flag), 0);
    end

    // single error in every coded position (R7 R8 R10)
    setcfg(1'b1, 1'b1, 1'b0);
    for (int pos = 0; pos < 14; pos++) begin
      for (int j = 0; j < 2; j++) begin
        logic [7:0] b;
        b = 8'((pos * 19 + j * 101 + 5) & 255);
        fstart();
        chk(!fec_fixed_flag, "R10 flag cleared by frame start", int'(fec_fixed_flag), 0);
        xfer(b, pos, -1, b);
        chk(fec_fixed_flag, "R7 R8 flag after correction", int'(fec_fixed_flag), 1);
      end
    end
    xfer(8'h3C, -1, -1, 8'h3C);
    chk(fec_fixed_flag, "R8 flag sticky over clean byte", int'(fec_fixed_flag), 1);

    // FEC under Manchester: invert a whole pair (R7 R9)
    setcfg(1'b0, 1'b1, 1'b1);
    for (int k = 0; k < 14; k++) begin
      fstart();
      xfer(8'(k * 17 + 3), 2 * k, 2 * k + 1, 8'(k * 17 + 3));
      chk(fec_fixed_flag && !manch_err_flag, "R7 pair-inverted bit corrected",
          {fec_fixed_flag, manch_err_flag}, 2'b10);
    end

    // invalid Manchester pairs (R9 R10)
    setcfg(1'b0, 1'b0, 1'b1);
    fstart();
    xfer(8'hA5, 1, -1, 8'hA5);
    chk(manch_err_flag, "R9 pair 11 flagged", int'(manch_err_flag), 1);
    fstart();
    chk(!manch_err_flag, "R10 pair flag cleared", int'(manch_err_flag), 0);
    xfer(8'hA5, 0, -1, 8'h25);
    chk(manch_err_flag, "R9 pair 00 flagged", int'(manch_err_flag), 1);

    // stray bit before frame start does not shift alignment (R10)
    setcfg(1'b1, 1'b1, 1'b1);
    fstart();
    @(negedge clk);
    rx_bit_valid = 1'b1; rx_bit = 1'b1;
    @(negedge clk);
    rx_bit_valid = 1'b0;
    fstart();
    xfer(8'h6E, -1, -1, 8'h6E);
    chk(!manch_err_flag && !fec_fixed_flag, "R10 realigned after stray bit",
        {manch_err_flag, fec_fixed_flag}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule